// File: doc/BRIEF.md
# Motor Bridge Drive and Fault Latch Controller

This block is the digital control core for a full motor bridge. The bridge has two high-side switches and two low-side gate drivers. Two direction inputs and two enable lines are decoded into four switch commands. Each enable line is also a diagnostic line: when a half bridge has a latched fault, the block pulls that line low.

Fault reports arrive as digital flags: overtemperature on a high side, saturation on a low-side switch, and supply undervoltage. A fault latches its half bridge off and removes both low-side gates. The latch clears only on a rising edge of that half bridge's direction input. The PWM input gates only the low-side gates. Each low-side gate waits a programmable dead time after any direction change before it may turn on.

A test mode checks load continuity. In this mode the low-side drivers stay off, the direction inputs switch the high sides directly, and an open-load flag pulls the matching diagnostic line low. Every asynchronous input passes through a multi-stage synchronizer.

Top module: `hb_ctrl`

## Requirements
- R1: With both effective enables high and no fault, each half bridge X drives its high side when its direction input is 1 and its low-side gate when it is 0. This gives both highs on for 11, high A with low B for 10, high B with low A for 01, and both lows for 00. A high side and the low-side gate of the same half are never on together.
- R2: With both enable lines low, all four switch outputs are 0 whatever the direction inputs are.
- R3: A low enable line removes only its own half bridge. The other half bridge still follows its own direction input as in R1.
- R4: When the synchronized PWM input is 0, both low-side gates are 0 and the high sides are unchanged. When PWM returns to 1, the gates return to the state given by R1 to R3.
- R5: A low-side gate that becomes requested because of a direction change stays 0 after the first 2+DEAD_CYCLES rising clock edges that follow the input change. It is 1 after edge 3+DEAD_CYCLES. The two-edge synchronizer latency is included in this count.
- R6: A synchronized overtemperature or saturation flag for half bridge X latches that half off. Diagnostic pull output X then goes to 1, high side X goes to 0, and both low-side gates go to 0. The other high side keeps following its direction input while its enable is high.
- R7: A latched fault stays set after its flag drops. It clears only on a rising edge of that half's synchronized direction input while its flag is 0. A rising edge seen while the flag is still 1 leaves the latch set.
- R8: In test mode both low-side gates are 0, and each high side follows its direction input under its enable. An open-load flag for half bridge X sets diagnostic pull X to 1, which also turns high side X off.
- R9: While the synchronized undervoltage flag is 1, all four switch outputs are 0. The outputs return to normal when the flag clears.
- R10: While rst_n is low at a clock edge, the block resets synchronously. After reset, all switch outputs and both pull outputs are 0 and no fault is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_a | input | 1 | Direction input, half bridge A |
| dir_b | input | 1 | Direction input, half bridge B |
| diag_a_in | input | 1 | Sensed level of the enable/diagnostic line A |
| diag_b_in | input | 1 | Sensed level of the enable/diagnostic line B |
| pwm_in | input | 1 | PWM gate for the low-side drivers |
| test_mode | input | 1 | Load-continuity test mode |
| uv_flag | input | 1 | Supply undervoltage flag |
| ovt_a | input | 1 | Overtemperature flag, high side A |
| ovt_b | input | 1 | Overtemperature flag, high side B |
| sat_a | input | 1 | Saturation flag, low-side switch A |
| sat_b | input | 1 | Saturation flag, low-side switch B |
| open_a | input | 1 | Open-load flag, output A (test mode) |
| open_b | input | 1 | Open-load flag, output B (test mode) |
| hs_a | output | 1 | High-side switch A command |
| hs_b | output | 1 | High-side switch B command |
| ls_a | output | 1 | Low-side gate A command |
| ls_b | output | 1 | Low-side gate B command |
| diag_a_pull | output | 1 | Pull-low enable for diagnostic line A |
| diag_b_pull | output | 1 | Pull-low enable for diagnostic line B |

## Verification
The bench sweeps every combination of the two direction inputs, the two enables and PWM. A decoder with swapped halves, or with PWM reaching the high sides, shows up as a wrong output vector in that sweep.

The dead-time window is sampled on the exact last-low edge and the first-high edge. An off-by-one counter therefore fails one of the two samples. A gate that glitches on in the cycle the change is first seen fails the all-low scan of the window.

Fault latches are tested for three cases: the flag dropping alone, a rising direction edge while the flag is still high, and a clean rising edge. A latch that clears too early, or never clears, is caught. Test mode and undervoltage are each checked for low-side gates that leak on.

// File: rtl/hb_pkg.sv
package hb_pkg;
   // Synchronized input bundle, one bit per asynchronous pin
   typedef struct packed {
      logic dir_a;
      logic dir_b;
      logic diag_a;
      logic diag_b;
      logic pwm;
      logic test;
      logic uv;
      logic ovt_a;
      logic ovt_b;
      logic sat_a;
      logic sat_b;
      logic open_a;
      logic open_b;
   } hb_in_t;

   localparam int unsigned HB_IN_W = $bits(hb_in_t);
   localparam int unsigned HB_HALVES = 2;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("hb_sync: STAGES must be at least 2");
   end

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stage[s] <= '0;
         end else if (s == 0) begin
            stage[s] <= d;
         end else begin
            stage[s] <= stage[(s == 0) ? 0 : s - 1];
         end
      end
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/hb_half.sv
module hb_half #(
   parameter int unsigned DEAD_CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_s,
   input  logic flag,
   input  logic restart,
   output logic dir_edge,
   output logic dir_rise,
   output logic fault,
   output logic dead_done
);
   localparam int unsigned CNT_W = $clog2(DEAD_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(DEAD_CYCLES);

   logic             dir_q;
   logic [CNT_W-1:0] cnt;

   assign dir_edge  = dir_s ^ dir_q;
   assign dir_rise  = dir_s & ~dir_q;
   assign dead_done = (cnt == '0) & ~restart;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dir_q <= 1'b0;
      end else begin
         dir_q <= dir_s;
      end
   end

   // Fault latch: a present flag wins over a clearing edge
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault <= 1'b0;
      end else if (flag) begin
         fault <= 1'b1;
      end else if (dir_rise) begin
         fault <= 1'b0;
      end
   end

   // Dead-time down counter, reloaded on any direction change
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= CNT_LOAD;
      end else if (restart) begin
         cnt <= CNT_LOAD;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end
endmodule

// File: rtl/hb_ctrl.sv
module hb_ctrl #(
   parameter int unsigned DEAD_CYCLES = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dir_a,
   input  logic dir_b,
   input  logic diag_a_in,
   input  logic diag_b_in,
   input  logic pwm_in,
   input  logic test_mode,
   input  logic uv_flag,
   input  logic ovt_a,
   input  logic ovt_b,
   input  logic sat_a,
   input  logic sat_b,
   input  logic open_a,
   input  logic open_b,
   output logic hs_a,
   output logic hs_b,
   output logic ls_a,
   output logic ls_b,
   output logic diag_a_pull,
   output logic diag_b_pull
);
   import hb_pkg::*;

   if (DEAD_CYCLES < 1) begin : g_bad_dead
      $error("hb_ctrl: DEAD_CYCLES must be at least 1");
   end

   hb_in_t raw_in, s;
   logic [HB_HALVES-1:0] dir_v, diag_v, flag_v, open_v;
   logic [HB_HALVES-1:0] edge_v, rise_v, fault_v, done_v;
   logic [HB_HALVES-1:0] pull_v, en_v, hs_v, ls_v;
   logic restart, any_fault, uv_s, pwm_s;

   assign raw_in = '{dir_a: dir_a, dir_b: dir_b, diag_a: diag_a_in,
                     diag_b: diag_b_in, pwm: pwm_in, test: test_mode,
                     uv: uv_flag, ovt_a: ovt_a, ovt_b: ovt_b,
                     sat_a: sat_a, sat_b: sat_b, open_a: open_a,
                     open_b: open_b};

   hb_sync #(.WIDTH(HB_IN_W), .STAGES(SYNC_STAGES)) i_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (raw_in),
      .q    (s)
   );

   assign dir_v  = {s.dir_b, s.dir_a};
   assign diag_v = {s.diag_b, s.diag_a};
   assign flag_v = {s.ovt_b | s.sat_b, s.ovt_a | s.sat_a};
   assign open_v = {s.open_b, s.open_a};
   assign uv_s   = s.uv;
   assign pwm_s  = s.pwm;

   assign restart   = |edge_v;
   assign any_fault = |fault_v;

   for (genvar h = 0; h < HB_HALVES; h++) begin : g_half
      hb_half #(.DEAD_CYCLES(DEAD_CYCLES)) i_half (
         .clk      (clk),
         .rst_n    (rst_n),
         .dir_s    (dir_v[h]),
         .flag     (flag_v[h]),
         .restart  (restart),
         .dir_edge (edge_v[h]),
         .dir_rise (rise_v[h]),
         .fault    (fault_v[h]),
         .dead_done(done_v[h])
      );

      assign pull_v[h] = fault_v[h] | (s.test & open_v[h]);
      assign en_v[h]   = diag_v[h] & ~pull_v[h];
      assign hs_v[h]   = ~uv_s & en_v[h] & dir_v[h] & ~fault_v[h];
      assign ls_v[h]   = ~uv_s & ~s.test & ~any_fault & pwm_s
                         & en_v[h] & ~dir_v[h] & done_v[h];
   end

   assign hs_a        = hs_v[0];
   assign hs_b        = hs_v[1];
   assign ls_a        = ls_v[0];
   assign ls_b        = ls_v[1];
   assign diag_a_pull = pull_v[0];
   assign diag_b_pull = pull_v[1];
endmodule

// File: rtl/hb_ctrl_chk.sv
module hb_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       hs_a,
   input logic       hs_b,
   input logic       ls_a,
   input logic       ls_b,
   input logic       diag_a_pull,
   input logic       diag_b_pull,
   input logic       uv_s,
   input logic       pwm_s,
   input logic       restart,
   input logic [1:0] fault_v,
   input logic [1:0] rise_v
);
   assert_no_shoot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_a && ls_a) && !(hs_b && ls_b));

   assert_pwm_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !pwm_s |-> (!ls_a && !ls_b));

   assert_dead_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (!ls_a && !ls_b));

   assert_fault_a_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_v[0] |-> (diag_a_pull && !hs_a && !ls_a && !ls_b));

   assert_fault_b_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fault_v[1] |-> (diag_b_pull && !hs_b && !ls_a && !ls_b));

   assert_hold_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_v[0] && !rise_v[0]) |=> fault_v[0]);

   assert_hold_b_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_v[1] && !rise_v[1]) |=> fault_v[1]);

   assert_uv_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
      uv_s |-> !(hs_a || hs_b || ls_a || ls_b));
endmodule

bind hb_ctrl hb_ctrl_chk i_hb_ctrl_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hs_a       (hs_a),
   .hs_b       (hs_b),
   .ls_a       (ls_a),
   .ls_b       (ls_b),
   .diag_a_pull(diag_a_pull),
   .diag_b_pull(diag_b_pull),
   .uv_s       (uv_s),
   .pwm_s      (pwm_s),
   .restart    (restart),
   .fault_v    (fault_v),
   .rise_v     (rise_v)
);

// File: tb/test_hb_ctrl.sv
module test_hb_ctrl;
   localparam int CLK_P = 10;
   localparam int DEAD  = 5;
   localparam int SETTLE = DEAD + 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic dir_a = 0, dir_b = 0, diag_a_in = 0, diag_b_in = 0, pwm_in = 0;
   logic test_mode = 0, uv_flag = 0, ovt_a = 0, ovt_b = 0;
   logic sat_a = 0, sat_b = 0, open_a = 0, open_b = 0;
   logic hs_a, hs_b, ls_a, ls_b, diag_a_pull, diag_b_pull;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_P/2) clk = ~clk;

   hb_ctrl #(.DEAD_CYCLES(DEAD), .SYNC_STAGES(2)) i_hb_ctrl (
      .clk(clk), .rst_n(rst_n), .dir_a(dir_a), .dir_b(dir_b),
      .diag_a_in(diag_a_in), .diag_b_in(diag_b_in), .pwm_in(pwm_in),
      .test_mode(test_mode), .uv_flag(uv_flag), .ovt_a(ovt_a),
      .ovt_b(ovt_b), .sat_a(sat_a), .sat_b(sat_b), .open_a(open_a),
      .open_b(open_b), .hs_a(hs_a), .hs_b(hs_b), .ls_a(ls_a),
      .ls_b(ls_b), .diag_a_pull(diag_a_pull), .diag_b_pull(diag_b_pull)
   );

   // Compare the output vector {hs_a,hs_b,ls_a,ls_b,pull_a,pull_b}
   task automatic chk(input string req, input logic [5:0] exp);
      logic [5:0] act;
      act = {hs_a, hs_b, ls_a, ls_b, diag_a_pull, diag_b_pull};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   function automatic logic [5:0] model(input logic da, db, ea, eb, pw);
      return {ea & da, eb & db, ea & ~da & pw, eb & ~db & pw, 1'b0, 1'b0};
   endfunction

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      wait_cyc(4);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 reset state", 6'b000000);

      // R1/R2/R3/R4 sweep over direction, enables and PWM
      for (int v = 0; v < 32; v++) begin
         {dir_a, dir_b, diag_a_in, diag_b_in, pwm_in} = 5'(v);
         wait_cyc(SETTLE);
         if (!pwm_in)
            chk("R4 pwm gates low sides", model(dir_a, dir_b, diag_a_in, diag_b_in, pwm_in));
         else if (diag_a_in && diag_b_in)
            chk("R1 drive decode", model(dir_a, dir_b, 1'b1, 1'b1, 1'b1));
         else if (!diag_a_in && !diag_b_in)
            chk("R2 standby", 6'b000000);
         else
            chk("R3 single half", model(dir_a, dir_b, diag_a_in, diag_b_in, 1'b1));
      end

      // R4 resume after PWM returns high
      {dir_a, dir_b, diag_a_in, diag_b_in, pwm_in} = 5'b00110;
      wait_cyc(SETTLE);
      chk("R4 pwm low, both lows off", 6'b000000);
      pwm_in = 1'b1;
      wait_cyc(4);
      chk("R4 pwm resume", 6'b001100);

      // R5 dead-time window on a direction change
      {dir_a, dir_b} = 2'b11;
      wait_cyc(SETTLE);
      chk("R5 setup both highs", 6'b110000);
      dir_a = 1'b0;
      begin
         bit early = 0;
         for (int k = 1; k <= 3 + DEAD; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (k <= 2 + DEAD && ls_a) early = 1;
            if (k == 2 + DEAD) chk("R5 last low edge", 6'b010000);
            if (k == 3 + DEAD) chk("R5 first high edge", 6'b011000);
         end
         checks++;
         if (early) begin
            fails++;
            $display("FAIL R5 window: actual=ls_a high early expected=low");
         end
      end

      // R6/R7 overtemperature on A with direction 10
      {dir_a, dir_b} = 2'b10;
      wait_cyc(SETTLE);
      chk("R1 state 10", 6'b100100);
      ovt_a = 1'b1;
      wait_cyc(4);
      chk("R6 fault A latched", 6'b000010);
      dir_b = 1'b1;
      wait_cyc(4);
      chk("R6 high B still follows", 6'b010010);
      ovt_a = 1'b0;
      wait_cyc(SETTLE);
      chk("R7 flag drop alone keeps latch", 6'b010010);
      dir_a = 1'b0;
      wait_cyc(4);
      dir_a = 1'b1;
      wait_cyc(4);
      chk("R7 rising edge clears", 6'b110000);

      // R7 rising edge while flag still high does not clear
      {dir_a, dir_b} = 2'b00;
      wait_cyc(SETTLE);
      chk("R1 state 00", 6'b001100);
      sat_b = 1'b1;
      wait_cyc(4);
      chk("R6 saturation B latched", 6'b000001);
      dir_b = 1'b1;
      wait_cyc(4);
      chk("R7 edge with flag high keeps latch", 6'b000001);
      sat_b = 1'b0;
      dir_b = 1'b0;
      wait_cyc(4);
      chk("R7 still latched after drop", 6'b000001);
      dir_b = 1'b1;
      wait_cyc(4);
      chk("R7 clean edge clears B", 6'b010000);

      // R8 test mode
      {dir_a, dir_b} = 2'b10;
      test_mode = 1'b1;
      wait_cyc(SETTLE);
      chk("R8 test mode lows off", 6'b100000);
      open_b = 1'b1;
      wait_cyc(4);
      chk("R8 open B pulls line", 6'b100001);
      open_b = 1'b0;
      open_a = 1'b1;
      wait_cyc(4);
      chk("R8 open A pulls and removes high A", 6'b000010);
      open_a = 1'b0;
      test_mode = 1'b0;
      wait_cyc(SETTLE);
      chk("R8 exit test mode", 6'b100100);

      // R9 undervoltage
      uv_flag = 1'b1;
      wait_cyc(4);
      chk("R9 undervoltage all off", 6'b000000);
      uv_flag = 1'b0;
      wait_cyc(4);
      chk("R9 recovery", 6'b100100);

      // R10 synchronous reset clears a latched fault
      ovt_b = 1'b1;
      wait_cyc(4);
      chk("R6 fault B latched", 6'b100001);
      ovt_b = 1'b0;
      rst_n = 1'b0;
      wait_cyc(2);
      chk("R10 outputs off in reset", 6'b000000);
      rst_n = 1'b1;
      wait_cyc(SETTLE);
      chk("R10 fault cleared by reset", 6'b100100);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule